// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the bit-level core of an SPI master. It takes parallel words from a transmit queue through a valid/ready handshake, shifts them out on a serial data line while clocking the bus, samples the returning serial line, and returns each received word to a receive queue as a one-cycle valid pulse. The serial clock comes from a reload divider. The word width (1 to 32 bits), clock polarity, clock phase, bit order and the level driven on the data line between words are all programmable.

Transmit and receive are switched off separately. With the transmitter off and the receiver on, the engine runs in receive-only mode. In that mode it clocks words only while a byte to-do counter is non-zero. The counter is loaded through a request port and counts down by the bytes in each word received. Settings are taken only in config mode, while the enable input is low. Raising enable freezes them and enters run mode. Lowering it returns to config mode once the current word has finished. The queues, error flags and chip selects sit outside the block.

Top module: `spi_shift_core`

## Requirements
- R1: With divider reload `cfg_br` = B, consecutive `sclk` edges within a word are exactly B+1 clock cycles apart, giving a serial clock of clk/(2·(B+1)).
- R2: A word carries `cfg_wlen`+1 bits: exactly that many sampling edges and 2·(`cfg_wlen`+1) `sclk` edges per word.
- R3: Between words `sclk` rests at `cfg_pol`.
- R4: With `cfg_ph`=1, bit k is on `mosi` before the first edge and is sampled on each leading edge (the edge away from the rest level). With `cfg_ph`=0, data changes on leading edges and is sampled on trailing edges.
- R5: With `cfg_msb`=1 the word's bit (`cfg_wlen`−k) is the k-th bit on the line. With `cfg_msb`=0 it is bit k. This applies both to bits sent and to where received bits are placed in `rx_data`.
- R6: When no word is shifting, and for the whole of a receive-only word, `mosi` drives `cfg_idle`.
- R7: With both `cfg_txoff` and `cfg_rxoff` set, `tx_ready` stays low and no word starts, even with `tx_valid` held high.
- R8: With only the transmitter off, no `sclk` activity occurs while `todo` is zero. A `req_we` write loads `todo`, and each received word lowers it by (`cfg_wlen`>>3)+1 bytes, saturating at zero. Words run until it reaches zero.
- R9: A `req_we` write while `todo` is non-zero is ignored.
- R10: With `cfg_rxoff` set, words are shifted but `rx_valid` never pulses.
- R11: Settings are captured only while `run_mode` is low, and changes while it is high have no effect. `busy` is high only while a word shifts. Lowering `cfg_en` mid-word keeps `run_mode` high until that word ends.
- R12: `rx_valid` pulses for one cycle, the cycle after the last `sclk` edge of a word, with the complete received word on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | 1 requests run mode, 0 requests config mode |
| cfg_br | input | 16 | Divider reload value |
| cfg_wlen | input | 5 | Bits per word minus one |
| cfg_pol | input | 1 | Serial clock rest level |
| cfg_ph | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_msb | input | 1 | 1: most significant bit first |
| cfg_idle | input | 1 | Level on `mosi` when not sending data |
| cfg_txoff | input | 1 | Transmitter off |
| cfg_rxoff | input | 1 | Receiver off |
| tx_valid | input | 1 | Transmit queue has a word |
| tx_data | input | 32 | Word to send |
| tx_ready | output | 1 | Engine accepts a word this cycle |
| rx_valid | output | 1 | Received word valid (one cycle) |
| rx_data | output | 32 | Received word |
| req_we | input | 1 | Load the receive-only byte request |
| req_count | input | 16 | Bytes requested |
| todo | output | 16 | Bytes still outstanding in receive-only mode |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is shifting |
| run_mode | output | 1 | 1 in run mode, 0 in config mode |

## Verification
The bench uses the default parameters: 32-bit data path, 16-bit divider and 16-bit request counter. These cover the full width range from a single bit to 32 bits, so both end cases of the bit-index arithmetic are exercised. A reload of 3 gives gaps wide enough to show an off-by-one in the divider. A 16-bit word in receive-only mode makes the to-do counter drop by two bytes per word rather than one.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

    // Position in the word of the k-th bit on the line.
    function automatic logic [4:0] line_pos(input logic [4:0] idx,
                                            input logic [4:0] wlen,
                                            input logic       msb);
        return msb ? (wlen - idx) : idx;
    endfunction

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
    parameter int BRW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [BRW-1:0] reload,
    output logic           tick
);
    logic [BRW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == reload) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == reload);

    // the divider restarts from zero for every word
    assert_div_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
    assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(reload)) |-> cnt_q <= reload);
endmodule

// File: rtl/spi_rx_todo.sv
module spi_rx_todo #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wr_val,
    input  logic          dec,
    input  logic [CW-1:0] dec_amt,
    output logic [CW-1:0] todo
);
    logic [CW-1:0] todo_d, todo_q;

    always_comb begin
        todo_d = todo_q;
        if (dec)                       todo_d = (todo_q > dec_amt) ? todo_q - dec_amt : '0;
        else if (wr && todo_q == '0)   todo_d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) todo_q <= '0;
        else        todo_q <= todo_d;
    end

    assign todo = todo_q;

    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && todo_q != '0 && !dec) |=> todo_q == $past(todo_q));
    assert_todo_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> todo_q < $past(todo_q));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DW  = 32,
    parameter int LW  = 5,
    parameter int BRW = 16,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic [BRW-1:0] cfg_br,
    input  logic [LW-1:0]  cfg_wlen,
    input  logic           cfg_pol,
    input  logic           cfg_ph,
    input  logic           cfg_msb,
    input  logic           cfg_idle,
    input  logic           cfg_txoff,
    input  logic           cfg_rxoff,
    input  logic           tx_valid,
    input  logic [DW-1:0]  tx_data,
    output logic           tx_ready,
    output logic           rx_valid,
    output logic [DW-1:0]  rx_data,
    input  logic           req_we,
    input  logic [CW-1:0]  req_count,
    output logic [CW-1:0]  todo,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic           busy,
    output logic           run_mode
);
    import spi_core_pkg::*;

    localparam int EW = LW + 1;

    typedef struct packed {
        logic [BRW-1:0] br;
        logic [LW-1:0]  wlen;
        logic           pol, ph, msb, idle, txoff, rxoff;
    } cfg_t;

    typedef struct packed {
        cfg_t           cfg;
        logic           run;
        eng_state_e     st;
        logic [EW-1:0]  edge_cnt;
        logic [DW-1:0]  txw;
        logic [DW-1:0]  rxw;
        logic           sclk;
        logic           rxv;
        logic [DW-1:0]  rxd;
    } regs_t;

    regs_t         d, q;
    logic          tick, shifting, last_edge, leading, sample;
    logic          start_tx, start_rx, rx_only, dec;
    logic [LW-1:0] samp_idx, out_idx;
    logic [EW-1:0] em1;
    logic [CW-1:0] dec_amt;

    assign shifting  = (q.st == ENG_SHIFT);
    assign last_edge = (q.edge_cnt == {q.cfg.wlen, 1'b1});
    assign leading   = ~q.edge_cnt[0];
    assign sample    = q.cfg.ph ? leading : ~leading;
    assign samp_idx  = q.edge_cnt[EW-1:1];
    assign em1       = q.edge_cnt - 1'b1;
    assign out_idx   = q.cfg.ph ? q.edge_cnt[EW-1:1]
                     : ((q.edge_cnt == '0) ? '0 : em1[EW-1:1]);
    assign rx_only   = q.cfg.txoff && !q.cfg.rxoff;
    assign tx_ready  = q.run && cfg_en && !shifting && !q.cfg.txoff;
    assign start_tx  = tx_ready && tx_valid;
    assign start_rx  = q.run && cfg_en && !shifting && rx_only && (todo != '0);
    assign dec       = shifting && tick && last_edge && q.cfg.txoff;
    assign dec_amt   = CW'(q.cfg.wlen >> 3) + CW'(1);

    spi_baud_tick #(.BRW(BRW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(shifting), .reload(q.cfg.br), .tick(tick)
    );

    spi_rx_todo #(.CW(CW)) u_todo (
        .clk(clk), .rst_n(rst_n), .wr(req_we), .wr_val(req_count),
        .dec(dec), .dec_amt(dec_amt), .todo(todo)
    );

    always_comb begin
        d     = q;
        d.rxv = 1'b0;
        if (!q.run) begin
            d.cfg = '{br: cfg_br, wlen: cfg_wlen, pol: cfg_pol, ph: cfg_ph,
                      msb: cfg_msb, idle: cfg_idle, txoff: cfg_txoff, rxoff: cfg_rxoff};
            if (cfg_en) d.run = 1'b1;
        end else if (!cfg_en && !shifting) begin
            d.run = 1'b0;
        end
        if (!shifting) begin
            d.sclk = q.cfg.pol;
            if (start_tx || start_rx) begin
                d.st       = ENG_SHIFT;
                d.edge_cnt = '0;
                d.txw      = start_tx ? tx_data : '0;
                d.rxw      = '0;
            end
        end else if (tick) begin
            d.sclk = ~q.sclk;
            if (sample)
                d.rxw[line_pos(samp_idx, q.cfg.wlen, q.cfg.msb)] = miso;
            if (last_edge) begin
                d.st       = ENG_IDLE;
                d.edge_cnt = '0;
                d.rxv      = !q.cfg.rxoff;
                d.rxd      = d.rxw;
            end else begin
                d.edge_cnt = q.edge_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cfg.ph   <= 1'b1;
            q.cfg.msb  <= 1'b1;
            q.cfg.idle <= 1'b1;
            q.cfg.txoff <= 1'b1;
            q.cfg.rxoff <= 1'b1;
            q.cfg.wlen <= LW'(7);
            q.st       <= ENG_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sclk     = q.sclk;
    assign busy     = shifting;
    assign run_mode = q.run;
    assign rx_valid = q.rxv;
    assign rx_data  = q.rxd;
    assign mosi     = (shifting && !q.cfg.txoff)
                    ? q.txw[line_pos(out_idx, q.cfg.wlen, q.cfg.msb)] : q.cfg.idle;

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && $past(q.run)) |-> $stable(q.cfg));
    assert_busy_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_mode);
    assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && q.run && $past(q.run)) |-> sclk == q.cfg.pol);
    assert_rxonly_mosi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.cfg.txoff) |-> mosi == q.cfg.idle);
    assert_rxoff_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.cfg.rxoff) |=> !rx_valid);
    assert_both_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg.txoff && q.cfg.rxoff && !busy) |=> !busy);
    assert_rx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_spi_shift_core.sv
module sim_spi_shift_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_br = '0;
    logic [4:0]  cfg_wlen = 5'd7;
    logic        cfg_pol = 1'b0, cfg_ph = 1'b1, cfg_msb = 1'b1, cfg_idle = 1'b1;
    logic        cfg_txoff = 1'b1, cfg_rxoff = 1'b1;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready, rx_valid, busy, run_mode, sclk, mosi;
    logic [31:0] rx_data;
    logic        req_we = 1'b0;
    logic [15:0] req_count = '0;
    logic [15:0] todo;
    logic        miso = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    // monitor state
    int          mon_k = 0, mon_edges = 0, gap = 0, gap_err = 0, rxv_cnt = 0, mosi_bad = 0;
    int          c_n = 8;
    logic [31:0] mon_stream = '0, slave_word = '0, rx_last = '0;
    logic        sclk_prev = 1'b0, mosi_prev = 1'b1;

    always #10 clk = ~clk;

    spi_shift_core u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_br(cfg_br), .cfg_wlen(cfg_wlen),
        .cfg_pol(cfg_pol), .cfg_ph(cfg_ph), .cfg_msb(cfg_msb), .cfg_idle(cfg_idle),
        .cfg_txoff(cfg_txoff), .cfg_rxoff(cfg_rxoff), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .req_we(req_we),
        .req_count(req_count), .todo(todo), .sclk(sclk), .mosi(mosi), .miso(miso),
        .busy(busy), .run_mode(run_mode)
    );

    function automatic logic sbit(input int k);
        int kk = k % c_n;
        return cfg_msb ? slave_word[c_n-1-kk] : slave_word[kk];
    endfunction

    function automatic logic [31:0] mask(input int n);
        logic [63:0] m = (64'd1 << n) - 64'd1;
        return m[31:0];
    endfunction

    // line monitor and slave model
    always @(negedge clk) begin
        if (sclk !== sclk_prev) begin
            logic lead, smp;
            lead = (sclk_prev == cfg_pol);
            smp  = cfg_ph ? lead : !lead;
            if (mon_edges > 0 && gap != int'(cfg_br) + 1) gap_err++;
            gap = 0;
            if (smp) begin
                if (mon_k < 32) mon_stream[mon_k] = mosi_prev;
                mon_k++;
                miso = sbit(mon_k);
            end
            mon_edges++;
        end
        gap++;
        if (rx_valid) begin rxv_cnt++; rx_last = rx_data; end
        if (busy && cfg_txoff && mosi !== cfg_idle) mosi_bad++;
        sclk_prev = sclk;
        mosi_prev = mosi;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic setcfg(input int br, input int n, input bit pol, input bit ph, input bit msb,
                          input bit idle, input bit txoff, input bit rxoff);
        step(); cfg_en = 1'b0;
        repeat (3) step();
        cfg_br = 16'(br); cfg_wlen = 5'(n - 1); c_n = n;
        cfg_pol = pol; cfg_ph = ph; cfg_msb = msb; cfg_idle = idle;
        cfg_txoff = txoff; cfg_rxoff = rxoff;
        step(); cfg_en = 1'b1;
        repeat (3) step();
    endtask

    task automatic mon_clear(input logic [31:0] sw);
        mon_k = 0; mon_edges = 0; gap_err = 0; rxv_cnt = 0; mosi_bad = 0;
        mon_stream = '0; slave_word = sw; miso = sbit(0);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((busy || todo != 0) && guard < 20000) begin step(); guard++; end
        step();
    endtask

    // one full-duplex word with the current settings
    task automatic xfer(input logic [31:0] txw, input logic [31:0] sw, input string tag);
        logic [31:0] exp_s = '0;
        step();
        mon_clear(sw);
        tx_valid = 1'b1; tx_data = txw;
        while (!tx_ready) step();
        step(); tx_valid = 1'b0;
        wait_idle();
        for (int k = 0; k < c_n; k++) exp_s[k] = cfg_msb ? txw[c_n-1-k] : txw[k];
        chk(mon_k == c_n, {tag, " R2 bit count"}, mon_k, c_n);
        chk(gap_err == 0, {tag, " R1 edge spacing"}, gap_err, 0);
        chk(mon_stream == exp_s, {tag, " R4/R5 line order"}, mon_stream, exp_s);
        chk(rxv_cnt == (cfg_rxoff ? 0 : 1), {tag, " R12 rx pulses"}, rxv_cnt, cfg_rxoff ? 0 : 1);
        if (!cfg_rxoff)
            chk(rx_last == (sw & mask(c_n)), {tag, " R5 R12 rx word"}, rx_last, sw & mask(c_n));
        chk(sclk == cfg_pol, {tag, " R3 rest level"}, sclk, cfg_pol);
        chk(mosi == cfg_idle, {tag, " R6 idle level"}, mosi, cfg_idle);
    endtask

    task automatic t_reset();
        chk(busy == 0 && run_mode == 0 && tx_ready == 0, "R11 reset state", {busy, run_mode, tx_ready}, 0);
        chk(rx_valid == 0 && todo == 0, "R8 reset todo", todo, 0);
        chk(sclk == 0 && mosi == 1, "R6 reset lines", {sclk, mosi}, 2'b01);
    endtask

    task automatic t_modes();
        setcfg(0, 8, 0, 1, 1, 1, 0, 0);  xfer(32'hA5, 32'h3C, "mode0 msb w8");
        setcfg(3, 12, 1, 0, 0, 0, 0, 0); xfer(32'h9C3, 32'h5A6, "mode3 lsb w12");
        setcfg(1, 32, 0, 0, 1, 1, 0, 0); xfer(32'hDEADBEEF, 32'h12345678, "mode1 msb w32");
        setcfg(2, 1, 1, 1, 0, 0, 0, 0);  xfer(32'h1, 32'h1, "mode2 lsb w1");
    endtask

    task automatic t_idle();
        setcfg(0, 8, 0, 1, 1, 0, 0, 0);
        chk(mosi == 0, "R6 idle low", mosi, 0);
        setcfg(0, 8, 0, 1, 1, 1, 0, 0);
        chk(mosi == 1, "R6 idle high", mosi, 1);
    endtask

    task automatic t_rxoff();
        setcfg(1, 8, 0, 1, 1, 1, 0, 1);
        xfer(32'h6B, 32'hFF, "R10 rx off");
    endtask

    task automatic t_both_off();
        int seen = 0;
        setcfg(0, 8, 0, 1, 1, 1, 1, 1);
        tx_valid = 1'b1; tx_data = 32'h55;
        for (int i = 0; i < 40; i++) begin step(); if (busy || tx_ready || sclk != cfg_pol) seen++; end
        tx_valid = 1'b0;
        chk(seen == 0, "R7 both off idle", seen, 0);
    endtask

    task automatic rx_only_run(input int n, input int bytes, input int words, input logic [31:0] sw,
                               input string tag);
        int moved = 0;
        setcfg(0, n, 0, 1, 1, 1, 1, 0);
        mon_clear(sw);
        for (int i = 0; i < 20; i++) begin step(); if (busy || sclk != cfg_pol) moved++; end
        chk(moved == 0, {tag, " R8 no clock before request"}, moved, 0);
        req_we = 1'b1; req_count = 16'(bytes);
        step(); req_we = 1'b0;
        chk(todo == 16'(bytes), {tag, " R8 request loaded"}, todo, bytes);
        wait_idle();
        chk(rxv_cnt == words, {tag, " R8 word count"}, rxv_cnt, words);
        chk(rx_last == (sw & mask(n)), {tag, " R8 rx data"}, rx_last, sw & mask(n));
        chk(mosi_bad == 0, {tag, " R8 mosi idle"}, mosi_bad, 0);
        chk(todo == 0, {tag, " R8 todo drained"}, todo, 0);
    endtask

    task automatic t_req_ignored();
        setcfg(1, 8, 0, 1, 1, 1, 1, 0);
        mon_clear(32'hC4);
        req_we = 1'b1; req_count = 16'd5;
        step(); req_count = 16'd9;
        step(); req_we = 1'b0;
        chk(todo == 16'd5, "R9 second write ignored", todo, 5);
        wait_idle();
        chk(rxv_cnt == 5, "R9 words after ignored write", rxv_cnt, 5);
    endtask

    task automatic t_frozen();
        setcfg(2, 8, 0, 1, 1, 1, 0, 0);
        step();
        mon_clear(32'h81);
        tx_valid = 1'b1; tx_data = 32'h3E;
        while (!tx_ready) step();
        step(); tx_valid = 1'b0;
        repeat (4) step();
        cfg_wlen = 5'd3; cfg_en = 1'b0;
        step();
        chk(run_mode == 1 && busy == 1, "R11 run held mid-word", {run_mode, busy}, 2'b11);
        wait_idle();
        chk(mon_k == 8, "R11 width frozen", mon_k, 8);
        chk(rx_last == 32'h81, "R11 word intact", rx_last, 32'h81);
        chk(run_mode == 0, "R11 config after word", run_mode, 0);
        cfg_wlen = 5'd7;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_modes();
        t_idle();
        t_rxoff();
        t_both_off();
        rx_only_run(8, 3, 3, 32'h5D, "rxonly w8");
        rx_only_run(16, 4, 2, 32'hBEEF, "rxonly w16");
        t_req_ignored();
        t_frozen();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule